// File: doc/BRIEF.md
# Interrupt Trigger Notification Generator

This block watches a bank of level-sensitive interrupt lines. It keeps their current levels in an assertion register and gives each source a two-bit event state, written as {P,Q}. When a line rises while its source sits in the idle state, the block queues a 64-bit notification store. The store goes to an address that software programs. Its data word combines a programmable vector-table base with the source number. A flag in the word marks that the event state was already checked inside the block.

Software configures the block through a simple register write port and a combinational read port. The write port holds the control word, the notification address, the vector-table offset and the event-page base. The read port returns those four registers, the assertion register and the packed event states. Notifications leave on a valid/ready stream. A store is presented with `st_valid` and holds its address and data unchanged until `st_ready` is seen high at a clock edge. A new store can follow in the very next cycle. Triggers that arrive while the stream is back-pressured wait in a pending set, and the lowest-numbered pending source is issued first.

Top module: `itn_notifier`

## Requirements
- R1: After reset `st_valid` and `lsi_err` are low, every register reads 0, and every source's event state reads 00 (enabled).
- R2: With the control word's bit 63 clear, read address 4 returns the assertion register, one clock after the inputs change. Source n appears at bit 63-n and follows `irq_in[n]`.
- R3: On a rising input, a source's state moves 00 to 10 and queues a notification. It moves 10 to 11 with no notification, stays at 11, and stays at 01 with no notification. Read address 5 returns source n's {P,Q} at bits 2n+1:2n.
- R4: The store data has bit 63 set and bits 62:32 zero. Bits 31:0 hold bits 63:32 of the vector-table offset register ORed with the source number.
- R5: Bit 0 of the notification address register is its valid flag. The store address is the register value with bit 0 cleared.
- R6: While the valid flag is clear, a 00-to-10 trigger queues nothing and no store is issued.
- R7: Once `st_valid` is high, it stays high with a stable address and data until a cycle with `st_ready` high.
- R8: When several sources are pending, they are issued in order of increasing source number.
- R9: While control bit 63 is set, input changes leave the assertion register and event states untouched. `lsi_err` goes high in the following cycle whenever an input differs from its recorded level.
- R10: A write to control address 0 with bit 62 set returns every event state to 00 and empties the pending set. A store already being presented is kept.
- R11: `page_64k` equals bit 62 of the event-page base register (address 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 20 | Interrupt line levels, one per source |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Write address: 0 control, 1 notify address, 2 vector offset, 3 page base |
| cfg_wdata | input | 64 | Write data |
| cfg_raddr | input | 3 | Read address: 0-3 as for writes, 4 assertion register, 5 event states |
| cfg_rdata | output | 64 | Read data, combinational |
| page_64k | output | 1 | Event-page size select: 1 for 64 KiB, 0 for 4 KiB |
| lsi_err | output | 1 | Input change seen while the level method is selected |
| st_valid | output | 1 | Notification store valid |
| st_ready | input | 1 | Notification store accepted |
| st_addr | output | 64 | Notification store address |
| st_data | output | 64 | Notification store data |

## Verification
The assertions assume that reset lasts at least one clock, with `cfg_we` held low during it. They also assume that `st_ready` is a plain level sampled at the clock edge, so that a held store is released only by it. The stimulus holds writes off during reset and drives every input only at the falling edge. Back-pressure is applied by holding `st_ready` low over several cycles while several lines rise together. A reference model built from arrays and integers is compared against the stream, the error flag and the read port after every clock.

// File: rtl/itn_pkg.sv
package itn_pkg;
  localparam int REG_W = 64;
  localparam int RA_W  = 3;

  typedef enum logic [1:0] {
    PQ_IDLE   = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_SENT   = 2'b10,
    PQ_REPEAT = 2'b11
  } pq_e;

  localparam logic [RA_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [RA_W-1:0] RA_NADDR = 3'd1;
  localparam logic [RA_W-1:0] RA_IVT   = 3'd2;
  localparam logic [RA_W-1:0] RA_PAGE  = 3'd3;
  localparam logic [RA_W-1:0] RA_LEVEL = 3'd4;
  localparam logic [RA_W-1:0] RA_PQ    = 3'd5;

  // MSB-numbered bit k sits at index REG_W-1-k
  localparam int CTRL_METHOD_IX = REG_W - 1;
  localparam int CTRL_RESET_IX  = REG_W - 2;
  localparam int PAGE_64K_IX    = REG_W - 2;
  localparam int NADDR_VLD_IX   = 0;
endpackage

// File: rtl/itn_level_track.sv
module itn_level_track #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lsi_mode,
  input  logic [N-1:0] irq_in,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic         err_o
);
  logic [N-1:0] level_q;
  logic         err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= lsi_mode && (irq_in != level_q);
      if (!lsi_mode) level_q <= irq_in;
    end
  end

  assign rise_o  = lsi_mode ? '0 : (irq_in & ~level_q);
  assign level_o = level_q;
  assign err_o   = err_q;
endmodule

// File: rtl/itn_pq_bank.sv
module itn_pq_bank
  import itn_pkg::*;
#(
  parameter int N = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_all,
  input  logic [N-1:0]   trig,
  output logic [2*N-1:0] pq_flat,
  output logic [N-1:0]   fire_o
);
  for (genvar s = 0; s < N; s++) begin : g_src
    pq_e pq_q;
    pq_e pq_d;

    always_comb begin
      pq_d = pq_q;
      if (trig[s]) begin
        unique case (pq_q)
          PQ_IDLE:   pq_d = PQ_SENT;
          PQ_SENT:   pq_d = PQ_REPEAT;
          PQ_REPEAT: pq_d = PQ_REPEAT;
          PQ_OFF:    pq_d = PQ_OFF;
          default:   pq_d = pq_q;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst || clr_all) pq_q <= PQ_IDLE;
      else                pq_q <= pq_d;
    end

    assign fire_o[s]           = trig[s] && (pq_q == PQ_IDLE);
    assign pq_flat[2*s +: 2]   = pq_q;
  end
endmodule

// File: rtl/itn_store_arb.sv
module itn_store_arb #(
  parameter int N        = 20,
  parameter int AW       = 64,
  parameter int DW       = 64,
  parameter bit PQ_CHECK = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic [N-1:0]  enq,
  input  logic          enable,
  input  logic [AW-1:0] base_addr,
  input  logic [DW/2-1:0] tag,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data
);
  localparam int TW = DW / 2;
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  pend_q;
  logic [N-1:0]  gnt;
  logic [SW-1:0] gnt_ix;
  logic          load;
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [TW-1:0] word;

  // lowest index wins
  always_comb begin
    gnt    = '0;
    gnt_ix = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        gnt_ix = SW'(i);
      end
    end
  end

  assign load = enable && (|pend_q) && (!valid_q || st_ready);
  assign word = tag | TW'(gnt_ix);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (clr_all) pend_q <= '0;
      else         pend_q <= (pend_q & ~(load ? gnt : '0)) | (enable ? enq : '0);
      if (load) begin
        valid_q <= 1'b1;
        addr_q  <= base_addr;
        data_q  <= {PQ_CHECK, {(DW-TW-1){1'b0}}, word};
      end else if (st_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign st_valid = valid_q;
  assign st_addr  = addr_q;
  assign st_data  = data_q;
endmodule

// File: rtl/itn_notifier.sv
module itn_notifier
  import itn_pkg::*;
#(
  parameter int N_SRC    = 20,
  parameter bit PQ_CHECK = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   irq_in,
  input  logic               cfg_we,
  input  logic [RA_W-1:0]    cfg_waddr,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic [RA_W-1:0]    cfg_raddr,
  output logic [REG_W-1:0]   cfg_rdata,
  output logic               page_64k,
  output logic               lsi_err,
  output logic               st_valid,
  input  logic               st_ready,
  output logic [REG_W-1:0]   st_addr,
  output logic [REG_W-1:0]   st_data
);
  localparam int TW = REG_W / 2;

  logic [REG_W-1:0]   ctrl_q, naddr_q, ivt_q, page_q;
  logic [N_SRC-1:0]   level, rise, fire;
  logic [2*N_SRC-1:0] pq_flat;
  logic               clr_all;
  logic [REG_W-1:0]   level_word;

  assign clr_all = cfg_we && (cfg_waddr == RA_CTRL) && cfg_wdata[CTRL_RESET_IX];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      naddr_q <= '0;
      ivt_q   <= '0;
      page_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_waddr)
        RA_CTRL:  ctrl_q  <= cfg_wdata;
        RA_NADDR: naddr_q <= cfg_wdata;
        RA_IVT:   ivt_q   <= cfg_wdata;
        RA_PAGE:  page_q  <= cfg_wdata;
        default:  ;
      endcase
    end
  end

  itn_level_track #(.N(N_SRC)) u_lvl (
    .clk      (clk),
    .rst      (rst),
    .lsi_mode (ctrl_q[CTRL_METHOD_IX]),
    .irq_in   (irq_in),
    .level_o  (level),
    .rise_o   (rise),
    .err_o    (lsi_err)
  );

  itn_pq_bank #(.N(N_SRC)) u_pq (
    .clk     (clk),
    .rst     (rst),
    .clr_all (clr_all),
    .trig    (rise),
    .pq_flat (pq_flat),
    .fire_o  (fire)
  );

  itn_store_arb #(.N(N_SRC), .AW(REG_W), .DW(REG_W), .PQ_CHECK(PQ_CHECK)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (clr_all),
    .enq       (fire),
    .enable    (naddr_q[NADDR_VLD_IX]),
    .base_addr (naddr_q & ~(REG_W'(1) << NADDR_VLD_IX)),
    .tag       (ivt_q[REG_W-1 -: TW]),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_addr   (st_addr),
    .st_data   (st_data)
  );

  always_comb begin
    level_word = '0;
    for (int n = 0; n < N_SRC; n++) level_word[REG_W-1-n] = level[n];
  end

  always_comb begin
    case (cfg_raddr)
      RA_CTRL:  cfg_rdata = ctrl_q;
      RA_NADDR: cfg_rdata = naddr_q;
      RA_IVT:   cfg_rdata = ivt_q;
      RA_PAGE:  cfg_rdata = page_q;
      RA_LEVEL: cfg_rdata = level_word;
      RA_PQ:    cfg_rdata = REG_W'(pq_flat);
      default:  cfg_rdata = '0;
    endcase
  end

  assign page_64k = page_q[PAGE_64K_IX];
endmodule

// File: rtl/itn_notifier_chk.sv
module itn_notifier_chk #(
  parameter int N_SRC    = 20,
  parameter bit PQ_CHECK = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               st_valid,
  input logic               st_ready,
  input logic [63:0]        st_addr,
  input logic [63:0]        st_data,
  input logic               lsi_err,
  input logic               lsi_mode,
  input logic               naddr_valid,
  input logic               clr_req,
  input logic [2*N_SRC-1:0] pq_flat
);
  AST_STORE_HELD: assert property (@(posedge clk) disable iff (rst)
    st_valid && !st_ready |=> st_valid && $stable(st_addr) && $stable(st_data)); // R7

  AST_ADDR_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> !st_addr[0]); // R5

  AST_DATA_FLAG: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> (st_data[63] == PQ_CHECK) && (st_data[62:32] == '0)); // R4

  AST_NO_STORE_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst)
    $rose(st_valid) |-> $past(naddr_valid)); // R6

  AST_ERR_ONLY_IN_LSI: assert property (@(posedge clk) disable iff (rst)
    lsi_err |-> $past(lsi_mode)); // R9

  AST_PQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(clr_req) |-> (pq_flat == '0)); // R10
endmodule

bind itn_notifier itn_notifier_chk #(.N_SRC(N_SRC), .PQ_CHECK(PQ_CHECK)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .st_valid    (st_valid),
  .st_ready    (st_ready),
  .st_addr     (st_addr),
  .st_data     (st_data),
  .lsi_err     (lsi_err),
  .lsi_mode    (ctrl_q[63]),
  .naddr_valid (naddr_q[0]),
  .clr_req     (clr_all),
  .pq_flat     (pq_flat)
);

// File: tb/itn_notifier_bench.sv
module itn_notifier_bench;
  localparam int CLK_P = 10;
  localparam int N     = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_waddr = '0;
  logic [63:0]   cfg_wdata = '0;
  logic [2:0]    cfg_raddr = '0;
  logic [63:0]   cfg_rdata;
  logic          page_64k, lsi_err, st_valid;
  logic          st_ready = 1'b1;
  logic [63:0]   st_addr, st_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  itn_notifier u_itn_notifier (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .page_64k(page_64k), .lsi_err(lsi_err),
    .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data)
  );

  // ---------------- reference model ----------------
  logic [63:0] m_ctrl, m_naddr, m_ivt, m_page;
  logic [N-1:0] m_lvl;
  int  m_pq [N];
  bit  m_pend [N];
  bit  m_sv, m_err;
  logic [63:0] m_sa, m_sd;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = '0; m_naddr = '0; m_ivt = '0; m_page = '0;
      m_lvl = '0; m_sv = 0; m_err = 0; m_sa = '0; m_sd = '0;
      for (int i = 0; i < N; i++) begin m_pq[i] = 0; m_pend[i] = 0; end
    end else begin
      bit meth, av, clr, found;
      logic [N-1:0] trig;
      meth = m_ctrl[63];
      av   = m_naddr[0];
      clr  = cfg_we && cfg_waddr == 3'd0 && cfg_wdata[62];
      if (m_sv && st_ready) m_sv = 0;
      found = 0;
      if (!m_sv && av) begin
        for (int i = 0; i < N; i++) begin
          if (!found && m_pend[i]) begin
            found = 1;
            m_pend[i] = 0;
            m_sv = 1;
            m_sa = {m_naddr[63:1], 1'b0};
            m_sd = {32'h8000_0000, m_ivt[63:32] | 32'(i)};
          end
        end
      end
      m_err = meth && (irq_in != m_lvl);
      trig  = meth ? '0 : (irq_in & ~m_lvl);
      if (!meth) m_lvl = irq_in;
      for (int i = 0; i < N; i++) begin
        if (clr) begin
          m_pq[i] = 0; m_pend[i] = 0;
        end else if (trig[i]) begin
          case (m_pq[i])
            0: begin m_pq[i] = 2; if (av) m_pend[i] = 1; end
            2: m_pq[i] = 3;
            default: ;
          endcase
        end
      end
      if (cfg_we) begin
        case (cfg_waddr)
          3'd0: m_ctrl  = cfg_wdata;
          3'd1: m_naddr = cfg_wdata;
          3'd2: m_ivt   = cfg_wdata;
          3'd3: m_page  = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [63:0] m_read(input logic [2:0] a);
    logic [63:0] r;
    r = '0;
    case (a)
      3'd0: r = m_ctrl;
      3'd1: r = m_naddr;
      3'd2: r = m_ivt;
      3'd3: r = m_page;
      3'd4: for (int n = 0; n < N; n++) r[63-n] = m_lvl[n];
      3'd5: for (int n = 0; n < N; n++) r[2*n +: 2] = 2'(m_pq[n]);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, a quarter period after the falling edge
  always @(negedge clk) begin
    #(CLK_P/4);
    if (!rst && !done) begin
      check("R7 R6 st_valid", 64'(st_valid), 64'(m_sv));
      if (m_sv) begin
        check("R5 st_addr", st_addr, m_sa);
        check("R4 R8 st_data", st_data, m_sd);
      end
      check("R9 lsi_err", 64'(lsi_err), 64'(m_err));
      check("R11 page_64k", 64'(page_64k), 64'(m_page[62]));
      check("R2 R3 cfg_rdata", cfg_rdata, m_read(cfg_raddr));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst = 0;
    @(negedge clk); #1;
    // R1: reset state
    check("R1 st_valid", 64'(st_valid), 0);
    cfg_raddr = 3'd5; #1; check("R1 pq states", cfg_rdata, 0);
    cfg_raddr = 3'd1; #1; check("R1 notify addr", cfg_rdata, 0);

    wr(3'd2, 64'h00A5_0000_1234_5678);
    wr(3'd1, 64'h0000_0000_0000_1001);
    cfg_raddr = 3'd4;

    // R2 R4: single rise on source 3
    irq_in[3] = 1;
    tick(1); #1;
    check("R2 level bit 60", 64'(cfg_rdata[60]), 1);
    tick(1); #1;
    check("R4 data src3", st_data, 64'h8000_0000_00A5_0003);
    check("R5 addr", st_addr, 64'h1000);

    // R3: second and third rise, no store
    cfg_raddr = 3'd5;
    irq_in[3] = 0; tick(1); irq_in[3] = 1; tick(2); #1;
    check("R3 src3 state 11", 64'(cfg_rdata[7:6]), 64'd3);
    check("R3 no repeat store", 64'(st_valid), 0);

    // R7 R8: back-pressure with several sources
    st_ready = 0;
    irq_in[7] = 1; irq_in[2] = 1; irq_in[5] = 1; irq_in[12] = 1;
    tick(4); #1;
    check("R8 first is src2", st_data[31:0], 32'h00A5_0002);
    st_ready = 1; tick(1); st_ready = 0; tick(2); #1;
    check("R8 second is src5", st_data[31:0], 32'h00A5_0005);
    st_ready = 1; tick(6);

    // R6: address valid clear
    wr(3'd1, 64'h0000_0000_0000_2000);
    irq_in[9] = 1; tick(3); #1;
    check("R6 no store", 64'(st_valid), 0);
    wr(3'd1, 64'h0000_0000_0000_2001);
    tick(3); #1;
    check("R6 not queued later", 64'(st_valid), 0);

    // R9: level method ignores inputs
    wr(3'd0, 64'h8000_0000_0000_0000);
    cfg_raddr = 3'd4;
    irq_in[15] = 1; tick(1); #1;
    check("R9 lsi_err", 64'(lsi_err), 1);
    check("R9 level unchanged", 64'(cfg_rdata[48]), 0);
    irq_in[15] = 0; tick(2);
    wr(3'd0, 64'h0);

    // R10: reset all event states, then re-trigger source 3
    wr(3'd0, 64'h4000_0000_0000_0000);
    cfg_raddr = 3'd5; #1;
    check("R10 states cleared", cfg_rdata, 0);
    irq_in[3] = 0; tick(1); irq_in[3] = 1; tick(2); #1;
    check("R10 renotify src3", st_data, 64'h8000_0000_00A5_0003);

    // R11: page size
    wr(3'd3, 64'h4000_0000_0000_0000); #1;
    check("R11 64k", 64'(page_64k), 1);
    wr(3'd3, 64'h0); #1;
    check("R11 4k", 64'(page_64k), 0);

    // many sources at once, full drain in order
    irq_in = '0; wr(3'd0, 64'h4000_0000_0000_0000);
    irq_in = {N{1'b1}}; tick(30);
    finish_run();
  end
endmodule